// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the write strobes that a host issues to a flash-style memory bus and recognises the multi-write command sequences that start an embedded operation. Each sequence opens with two unlock writes. A third write names the command. Programming needs one more write, which carries the target. The erase family needs a second unlock pair and a final write that selects sector erase, chip erase or the boot-region lock. A recognised sequence produces a single-cycle request pulse towards the program/erase engine, together with the address and data of the final write.

The decoder also holds two pieces of mode state. The first is the identification mode, which is entered and left by command. The second is a sticky boot-lock flag. While identification mode is active, a separate read address port returns the manufacturer code, the device code and the lock status. Only the low data byte takes part in command matching. While the engine reports busy, writes are discarded.

Top module: `fcmd_decoder`

## Requirements
- R1: After reset, all four request outputs are low, `id_mode` is 0, `boot_locked` is 0 and `id_rd_data` is 0. The sequence state is idle.
- R2: The program sequence is four writes: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then any address and data. In the cycle after the fourth write's clock edge, `req_program` is high for exactly one cycle. During that cycle `req_addr` and `req_data` equal that write's address and full data.
- R3: The sector erase sequence is six writes: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then any address with low data byte 30h. This pulses `req_sector_erase` with `req_addr` equal to the sixth write's address.
- R4: The chip erase sequence is the same erase prefix followed by a sixth write of 5555h/10h. This pulses `req_chip_erase`.
- R5: The boot-lock sequence is the same erase prefix followed by a sixth write of 5555h/40h. This pulses `req_boot_lock` and sets `boot_locked`. The flag then stays 1 through all later commands until reset.
- R6: Data bits 15 to 8 of a write have no effect on command matching.
- R7: A write that does not match the next expected step returns the decoder to idle without a request. That write does not count as a first unlock step.
- R8: A write presented while `busy` is 1 is ignored: it produces no request and leaves the sequence position unchanged.
- R9: The three writes 5555h/AAh, 2AAAh/55h, 5555h/90h set `id_mode` at the third write's clock edge. The same pair followed by 5555h/F0h clears it. Neither write produces a request pulse.
- R10: While `id_mode` is 1, `id_rd_data` returns MFR_CODE at read address 0 and DEV_CODE at read address 1. At read address 2 it returns `boot_locked` in bit 0 with the other bits 0. It returns 0 at any other read address. While `id_mode` is 0, it returns 0.
- R11: At most one request output is high in any cycle, and no request is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | DATA_W | Data of the write |
| busy | input | 1 | Engine busy; writes are ignored while high |
| rd_addr | input | ADDR_W | Identification read address |
| req_program | output | 1 | Program request pulse |
| req_sector_erase | output | 1 | Sector erase request pulse |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_boot_lock | output | 1 | Boot-lock request pulse |
| req_addr | output | ADDR_W | Address of the final write of the request |
| req_data | output | DATA_W | Data of the final write of the request |
| id_mode | output | 1 | Identification mode active |
| boot_locked | output | 1 | Sticky boot-lock flag |
| id_rd_data | output | DATA_W | Identification read data |

## Verification
On every cycle the assertions check four things. Requests are mutually exclusive single-cycle pulses. A busy cycle neither advances the sequence nor yields a request. The lock flag never falls. Identification data is zero outside identification mode. They also tie each sector-erase pulse to a 30h code and each identification event to the mode register. Only the bench scenarios can show that each complete sequence yields the right request with the right address and data, and that a broken or busy-interrupted sequence yields none. The same holds for upper data bits being ignored, for the identification read values before and after locking, and for reset clearing a half-entered sequence.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_ERA0, ST_ERA1, ST_ERA2
  } seq_st_e;

  typedef enum logic [2:0] {
    EV_NONE, EV_PROG, EV_SECT, EV_CHIP, EV_LOCK, EV_ID_ON, EV_ID_OFF
  } evt_e;

  localparam logic [31:0] KEY_ADDR_A = 32'h0000_5555;
  localparam logic [31:0] KEY_ADDR_B = 32'h0000_2AAA;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_ID_ON  = 8'h90;
  localparam logic [7:0]  CMD_ID_OFF = 8'hF0;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;
  localparam logic [7:0]  CMD_SECT   = 8'h30;
  localparam logic [7:0]  CMD_LOCK   = 8'h40;

  // address/code pair match; code is only the low data byte
  function automatic logic pair_is(input logic [31:0] addr, input logic [7:0] code,
                                   input logic [31:0] k_addr, input logic [7:0] k_code);
    return (addr == k_addr) && (code == k_code);
  endfunction

  // identification read map
  function automatic logic [15:0] id_word(input logic [31:0] addr, input logic locked,
                                          input logic [15:0] mfr, input logic [15:0] dev);
    case (addr)
      32'd0:   return mfr;
      32'd1:   return dev;
      32'd2:   return {15'd0, locked};
      default: return 16'd0;
    endcase
  endfunction

endpackage

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output evt_e              nxt_evt,
  output evt_e              evt_q,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [DATA_W-1:0] evt_data
);

  seq_st_e     st_q, st_d;
  logic        take;
  logic [31:0] a32;
  logic [7:0]  code;

  assign take = wr_en && !busy;
  assign a32  = 32'(wr_addr);
  assign code = wr_data[7:0];

  always_comb begin
    st_d    = st_q;
    nxt_evt = EV_NONE;
    if (take) begin
      st_d = ST_IDLE;
      case (st_q)
        ST_IDLE: if (pair_is(a32, code, KEY_ADDR_A, KEY_DATA_A)) st_d = ST_UNL1;
        ST_UNL1: if (pair_is(a32, code, KEY_ADDR_B, KEY_DATA_B)) st_d = ST_UNL2;
        ST_UNL2: begin
          if (pair_is(a32, code, KEY_ADDR_A, CMD_PROG))        st_d = ST_PROG;
          else if (pair_is(a32, code, KEY_ADDR_A, CMD_ERASE))  st_d = ST_ERA0;
          else if (pair_is(a32, code, KEY_ADDR_A, CMD_ID_ON))  nxt_evt = EV_ID_ON;
          else if (pair_is(a32, code, KEY_ADDR_A, CMD_ID_OFF)) nxt_evt = EV_ID_OFF;
        end
        ST_PROG: nxt_evt = EV_PROG;
        ST_ERA0: if (pair_is(a32, code, KEY_ADDR_A, KEY_DATA_A)) st_d = ST_ERA1;
        ST_ERA1: if (pair_is(a32, code, KEY_ADDR_B, KEY_DATA_B)) st_d = ST_ERA2;
        ST_ERA2: begin
          if (code == CMD_SECT)                              nxt_evt = EV_SECT;
          else if (pair_is(a32, code, KEY_ADDR_A, CMD_CHIP)) nxt_evt = EV_CHIP;
          else if (pair_is(a32, code, KEY_ADDR_A, CMD_LOCK)) nxt_evt = EV_LOCK;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      evt_q    <= EV_NONE;
      evt_addr <= '0;
      evt_data <= '0;
    end else begin
      st_q  <= st_d;
      evt_q <= nxt_evt;
      if (take) begin
        evt_addr <= wr_addr;
        evt_data <= wr_data;
      end
    end
  end

  // R8: a busy cycle neither moves the sequence nor yields a request
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(st_q) && evt_q == EV_NONE));

  // R7: every issued event leaves the sequencer idle
  a_r7_idle_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q != EV_NONE) |-> (st_q == ST_IDLE));

  // R3: a sector erase event was caused by a 30h code
  a_r3_sector_code: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q == EV_SECT) |-> ($past(wr_data[7:0]) == CMD_SECT));

endmodule

// File: rtl/fcmd_mode.sv
module fcmd_mode
  import fcmd_pkg::*;
#(
  parameter int          ADDR_W   = 17,
  parameter int          DATA_W   = 16,
  parameter logic [15:0] MFR_CODE = 16'h00C5,
  parameter logic [15:0] DEV_CODE = 16'h0E3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  evt_e              nxt_evt,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              id_mode,
  output logic              locked,
  output logic [DATA_W-1:0] id_rd_data
);

  logic [15:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_mode <= 1'b0;
      locked  <= 1'b0;
    end else begin
      if (nxt_evt == EV_ID_ON)  id_mode <= 1'b1;
      if (nxt_evt == EV_ID_OFF) id_mode <= 1'b0;
      if (nxt_evt == EV_LOCK)   locked  <= 1'b1;
    end
  end

  assign word       = id_word(32'(rd_addr), locked, MFR_CODE, DEV_CODE);
  assign id_rd_data = id_mode ? DATA_W'(word) : '0;

  // R5: lock is sticky
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R9: identification events reach the mode register
  a_r9_id_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_evt == EV_ID_ON) |=> id_mode);
  a_r9_id_leave: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_evt == EV_ID_OFF) |=> !id_mode);

  // R10: nothing is returned outside identification mode
  a_r10_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |-> (id_rd_data == '0));

endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter int          ADDR_W   = 17,
  parameter int          DATA_W   = 16,
  parameter logic [15:0] MFR_CODE = 16'h00C5,
  parameter logic [15:0] DEV_CODE = 16'h0E3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              req_program,
  output logic              req_sector_erase,
  output logic              req_chip_erase,
  output logic              req_boot_lock,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              id_mode,
  output logic              boot_locked,
  output logic [DATA_W-1:0] id_rd_data
);

  evt_e nxt_evt;
  evt_e evt_q;
  logic req_any;

  fcmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .nxt_evt(nxt_evt), .evt_q(evt_q), .evt_addr(req_addr), .evt_data(req_data)
  );

  fcmd_mode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
              .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_mode (
    .clk(clk), .rst_n(rst_n), .nxt_evt(nxt_evt), .rd_addr(rd_addr),
    .id_mode(id_mode), .locked(boot_locked), .id_rd_data(id_rd_data)
  );

  assign req_program      = (evt_q == EV_PROG);
  assign req_sector_erase = (evt_q == EV_SECT);
  assign req_chip_erase   = (evt_q == EV_CHIP);
  assign req_boot_lock    = (evt_q == EV_LOCK);
  assign req_any = req_program | req_sector_erase | req_chip_erase | req_boot_lock;

  // R11: exclusive, single-cycle requests
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_program, req_sector_erase, req_chip_erase, req_boot_lock}));
  a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |=> !req_any);

  // R5: a lock request is followed by the flag being set
  a_r5_lock_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_boot_lock |-> boot_locked);

endmodule

// File: tb/fcmd_decoder_test.sv
`timescale 1ns/1ps
module fcmd_decoder_test;

  localparam int          AW  = 17;
  localparam int          DW  = 16;
  localparam logic [15:0] MFR = 16'h00C5;
  localparam logic [15:0] DEV = 16'h0E3A;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          req_program, req_sector_erase, req_chip_erase, req_boot_lock;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          id_mode, boot_locked;
  logic [DW-1:0] id_rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  fcmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .MFR_CODE(MFR), .DEV_CODE(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_addr(rd_addr), .req_program(req_program),
    .req_sector_erase(req_sector_erase), .req_chip_erase(req_chip_erase),
    .req_boot_lock(req_boot_lock), .req_addr(req_addr), .req_data(req_data),
    .id_mode(id_mode), .boot_locked(boot_locked), .id_rd_data(id_rd_data)
  );

  // request code seen at the ports: 0 none, 1 program, 2 sector, 3 chip, 4 lock, 7 several
  function automatic int req_code();
    int n;
    n = int'(req_program) + int'(req_sector_erase) + int'(req_chip_erase) + int'(req_boot_lock);
    if (n > 1) return 7;
    if (req_program) return 1;
    if (req_sector_erase) return 2;
    if (req_chip_erase) return 3;
    if (req_boot_lock) return 4;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bus write; returns sampled just after the capturing edge
  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    bus_write(17'h05555, 16'h00AA);
    bus_write(17'h02AAA, 16'h0055);
  endtask

  // vector: addr[36:20] data[19:4] expected request[3:1] expected id_mode[0]
  localparam int NV = 32;
  localparam logic [36:0] VEC [NV] = '{
    {17'h05555, 16'h00AA, 3'd0, 1'b0}, {17'h02AAA, 16'h0055, 3'd0, 1'b0},
    {17'h05555, 16'h00A0, 3'd0, 1'b0}, {17'h01234, 16'hBEEF, 3'd1, 1'b0},
    {17'h05555, 16'h12AA, 3'd0, 1'b0}, {17'h02AAA, 16'hFF55, 3'd0, 1'b0},
    {17'h05555, 16'h7780, 3'd0, 1'b0}, {17'h05555, 16'h00AA, 3'd0, 1'b0},
    {17'h02AAA, 16'h0055, 3'd0, 1'b0}, {17'h06000, 16'hFF30, 3'd2, 1'b0},
    {17'h05555, 16'h00AA, 3'd0, 1'b0}, {17'h02AAA, 16'h0055, 3'd0, 1'b0},
    {17'h05555, 16'h0080, 3'd0, 1'b0}, {17'h05555, 16'h00AA, 3'd0, 1'b0},
    {17'h02AAA, 16'h0055, 3'd0, 1'b0}, {17'h05555, 16'h0010, 3'd3, 1'b0},
    {17'h05555, 16'h00AA, 3'd0, 1'b0}, {17'h02AAA, 16'h00AA, 3'd0, 1'b0},
    {17'h05555, 16'h00A0, 3'd0, 1'b0}, {17'h01234, 16'h5678, 3'd0, 1'b0},
    {17'h05555, 16'h00AA, 3'd0, 1'b0}, {17'h02AAA, 16'h0055, 3'd0, 1'b0},
    {17'h05555, 16'h0080, 3'd0, 1'b0}, {17'h05555, 16'h00AA, 3'd0, 1'b0},
    {17'h02AAA, 16'h0055, 3'd0, 1'b0}, {17'h05555, 16'h0011, 3'd0, 1'b0},
    {17'h05555, 16'h00AA, 3'd0, 1'b0}, {17'h02AAA, 16'h0055, 3'd0, 1'b0},
    {17'h05555, 16'h0090, 3'd0, 1'b1}, {17'h05555, 16'h00AA, 3'd0, 1'b1},
    {17'h02AAA, 16'h0055, 3'd0, 1'b1}, {17'h05555, 16'h00F0, 3'd0, 1'b0}
  };

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(req_code() == 0, "R1 requests", 32'(req_code()), 0);
    check(!id_mode && !boot_locked, "R1 mode/lock", {id_mode, boot_locked}, 0);
    check(id_rd_data == 0, "R1 id data", 32'(id_rd_data), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table: R2 R3 R4 R6 (upper bytes) R7 (broken) R9 (id entry/exit) R11
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int            er;
      logic          em;
      a  = VEC[i][36:20];
      d  = VEC[i][19:4];
      er = int'(VEC[i][3:1]);
      em = VEC[i][0];
      bus_write(a, d);
      check(req_code() == er, $sformatf("R2 R3 R4 R6 R7 R11 vector %0d request", i),
            32'(req_code()), 32'(er));
      check(id_mode == em, $sformatf("R9 vector %0d id_mode", i), 32'(id_mode), 32'(em));
      if (er == 1 || er == 2) begin
        check(req_addr == a, $sformatf("R2 R3 vector %0d addr", i), 32'(req_addr), 32'(a));
        check(req_data == d, $sformatf("R2 vector %0d data", i), 32'(req_data), 32'(d));
      end
      if (er != 0) begin
        @(posedge clk);
        #1;
        check(req_code() == 0, "R11 pulse width", 32'(req_code()), 0);
      end
    end

    // R10 identification reads, unlocked
    unlock();
    bus_write(17'h05555, 16'h0090);
    rd_addr = 17'd0; #1;
    check(id_rd_data == MFR, "R10 mfr code", 32'(id_rd_data), 32'(MFR));
    rd_addr = 17'd1; #1;
    check(id_rd_data == DEV, "R10 dev code", 32'(id_rd_data), 32'(DEV));
    rd_addr = 17'd2; #1;
    check(id_rd_data == 16'd0, "R10 lock clear", 32'(id_rd_data), 0);
    rd_addr = 17'd3; #1;
    check(id_rd_data == 16'd0, "R10 other addr", 32'(id_rd_data), 0);

    // R5 boot lock
    unlock();
    bus_write(17'h05555, 16'h0080);
    unlock();
    bus_write(17'h05555, 16'h0040);
    check(req_code() == 4, "R5 lock request", 32'(req_code()), 4);
    check(boot_locked, "R5 lock flag", 32'(boot_locked), 1);
    rd_addr = 17'd2; #1;
    check(id_rd_data == 16'd1, "R10 lock reported", 32'(id_rd_data), 1);
    unlock();
    bus_write(17'h05555, 16'h00F0);
    check(id_rd_data == 16'd0, "R10 exit hides data", 32'(id_rd_data), 0);
    unlock();
    bus_write(17'h05555, 16'h0080);
    unlock();
    bus_write(17'h05555, 16'h0010);
    check(req_code() == 3 && boot_locked, "R5 lock sticky after erase",
          {req_code() == 3, boot_locked}, 32'h3);

    // R8 busy: whole sequence ignored
    busy = 1'b1;
    unlock();
    bus_write(17'h05555, 16'h00A0);
    bus_write(17'h00100, 16'h1111);
    check(req_code() == 0, "R8 busy no request", 32'(req_code()), 0);
    busy = 1'b0;
    bus_write(17'h00100, 16'h1111);
    check(req_code() == 0, "R8 state stayed idle", 32'(req_code()), 0);
    // R8 busy mid-sequence keeps the position
    unlock();
    busy = 1'b1;
    bus_write(17'h01111, 16'h0033);
    busy = 1'b0;
    bus_write(17'h05555, 16'h00A0);
    bus_write(17'h02000, 16'h1234);
    check(req_code() == 1, "R8 position kept", 32'(req_code()), 1);
    check(req_data == 16'h1234, "R8 program data", 32'(req_data), 32'h1234);

    // R1 reset mid-sequence clears position and lock
    unlock();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(!boot_locked && !id_mode, "R1 reset clears mode", {boot_locked, id_mode}, 0);
    bus_write(17'h05555, 16'h00A0);
    bus_write(17'h02000, 16'h4321);
    check(req_code() == 0, "R1 sequence cleared", 32'(req_code()), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule